// File: doc/BRIEF.md
# Eight-Bit Timer with Two Compare Channels

This block is an 8-bit up-counter. It advances on a single-cycle count enable. That enable comes either from a tap of a free-running prescaler or from edges on an external input pin. The external pin is sampled exactly as it arrives and counted on the edge that software selects. Because nothing gates the pin, firmware can step the counter by toggling a pin it drives itself.

Two compare channels, A and B, watch the counter. On each count enable the present counter value is compared with each channel's compare register. An equal value raises the channel's flag and toggles the channel's waveform output. A third flag marks the wrap from 8'hFF to 8'h00. Each interrupt request is its flag gated by a mask bit.

Software reaches everything through one small register port. A write to the counter suppresses compare matches on the next count enable. Because of this, loading the counter with a compare value does not fire that channel at once.

Top module: `tc8_dualcmp`

## Requirements
- R1: While rst_n is low, every register (counter, both compare values, mask, flags, clock select), the prescaler, the pin synchroniser, both waveform outputs and every interrupt request are 0.
- R2: Register 5 bits [2:0] hold the clock select. Its codes are: 0 stops counting; 1, 2, 3, 4 and 5 give a count enable every 1, 8, 64, 256 and 1024 clocks. The enable comes from a 10-bit prescaler that increments on every clock from reset. The enable is active in cycles where the low 0, 3, 6, 8 or 10 prescaler bits are all ones.
- R3: Clock select 6 counts falling edges of ext_pin and code 7 counts rising edges. The pin passes two synchroniser flops and an edge detector. A pin change set up before one rising clock edge moves the counter on the third rising edge.
- R4: The register map is: 0 counter, 1 compare A, 2 compare B, 3 mask, 4 flags, 5 clock select. Addresses 6 and 7 read 0 and ignore writes. rd_data follows addr combinationally. A write to the counter loads wdata, and a count enable in the same cycle is discarded.
- R5: A count enable while the counter holds 8'hFF wraps it to 8'h00 and sets flag bit 0 (overflow).
- R6: On a count enable, when the counter equals a channel's compare value, that channel's flag is set. Compare A uses flag bit 1 and compare B uses flag bit 2. The channel's waveform output toggles on the same clock edge. No match fires while the counter is not enabled.
- R7: After a counter write, the next accepted count enable produces no compare match on either channel. Overflow is not suppressed.
- R8: Writing register 4 clears each flag whose wdata bit is 1 and leaves the others alone. A flag set by hardware in the same cycle stays set.
- R9: irq_ovf, irq_cmp_a and irq_cmp_b are flag bits 0, 1 and 2 ANDed with mask bits 0, 1 and 2.
- R10: The mask (register 3) and the clock select (register 5) store only bits [2:0]. Bits [7:3] of registers 3, 4 and 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External count source, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Register write data |
| rd_data | output | 8 | Read data for addr |
| irq_ovf | output | 1 | Masked overflow request |
| irq_cmp_a | output | 1 | Masked compare A request |
| irq_cmp_b | output | 1 | Masked compare B request |
| wave_a | output | 1 | Toggles on each compare A match |
| wave_b | output | 1 | Toggles on each compare B match |

## Verification
The bench loads the counter with a compare value while counting runs. A design that fails to block would toggle the waveform and set the flag at once. A design that blocks too long would miss the match one full wrap later. Counter writes land in the same cycle as a count enable, so a design that lets the enable through shows a counter one too high. Flag clears are issued while hardware sets the same flag, which catches a clear that wins. External edges are timed against the three-edge latency, which exposes a missing or extra synchroniser stage and a wrong edge polarity.

// File: rtl/tc8_pkg.sv
package tc8_pkg;
  localparam int NCMP = 2;
  localparam int NFLG = NCMP + 1;
  localparam int AW   = 3;

  typedef enum logic [2:0] {
    CS_STOP    = 3'd0,
    CS_DIV1    = 3'd1,
    CS_DIV8    = 3'd2,
    CS_DIV64   = 3'd3,
    CS_DIV256  = 3'd4,
    CS_DIV1024 = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  localparam logic [AW-1:0] A_CNT  = 3'd0;
  localparam logic [AW-1:0] A_CMPA = 3'd1;
  localparam logic [AW-1:0] A_CMPB = 3'd2;
  localparam logic [AW-1:0] A_MASK = 3'd3;
  localparam logic [AW-1:0] A_FLAG = 3'd4;
  localparam logic [AW-1:0] A_CTRL = 3'd5;

  localparam int F_OVF = 0;
  localparam int F_CA  = 1;
  localparam int F_CB  = 2;
endpackage

// File: rtl/tc8_clksel.sv
module tc8_clksel
  import tc8_pkg::*;
#(
  parameter int PSC_W  = 10,
  parameter int SYNC_N = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  input  logic     ext_pin,
  output logic     tick
);
  localparam int T8    = 3;
  localparam int T64   = 6;
  localparam int T256  = 8;
  localparam int T1024 = 10;

  logic [PSC_W-1:0]  psc_q, psc_d;
  logic [SYNC_N-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;
  logic              pin_s, rise, fall;
  logic              tap8, tap64, tap256, tap1024;

  always_comb begin
    psc_d  = psc_q + 1'b1;
    sync_d = {sync_q[SYNC_N-2:0], ext_pin};
    pin_s  = sync_q[SYNC_N-1];
    prev_d = pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      psc_q  <= psc_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    tap8    = &psc_q[T8-1:0];
    tap64   = &psc_q[T64-1:0];
    tap256  = &psc_q[T256-1:0];
    tap1024 = &psc_q[T1024-1:0];
    rise    = pin_s & ~prev_q;
    fall    = ~pin_s & prev_q;
    case (sel)
      CS_STOP:     tick = 1'b0;
      CS_DIV1:     tick = 1'b1;
      CS_DIV8:     tick = tap8;
      CS_DIV64:    tick = tap64;
      CS_DIV256:   tick = tap256;
      CS_DIV1024:  tick = tap1024;
      CS_EXT_FALL: tick = fall;
      CS_EXT_RISE: tick = rise;
      default:     tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tc8_cfg.sv
module tc8_cfg
  import tc8_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            addr,
  input  logic [CW-1:0]            wdata,
  output logic [NCMP-1:0][CW-1:0]  cmp,
  output logic [NFLG-1:0]          mask,
  output clk_sel_e                 sel
);
  logic [NCMP-1:0][CW-1:0] cmp_q, cmp_d;
  logic [NFLG-1:0]         mask_q, mask_d;
  clk_sel_e                sel_q, sel_d;

  always_comb begin
    cmp_d  = cmp_q;
    mask_d = mask_q;
    sel_d  = sel_q;
    if (wr_en) begin
      case (addr)
        A_CMPA:  cmp_d[0] = wdata;
        A_CMPB:  cmp_d[1] = wdata;
        A_MASK:  mask_d   = wdata[NFLG-1:0];
        A_CTRL:  sel_d    = clk_sel_e'(wdata[2:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mask_q <= '0;
      sel_q  <= CS_STOP;
    end else begin
      cmp_q  <= cmp_d;
      mask_q <= mask_d;
      sel_q  <= sel_d;
    end
  end

  assign cmp  = cmp_q;
  assign mask = mask_q;
  assign sel  = sel_q;
endmodule

// File: rtl/tc8_core.sv
module tc8_core
  import tc8_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    cnt_wr,
  input  logic [CW-1:0]           wdata,
  input  logic [NCMP-1:0][CW-1:0] cmp,
  input  logic [NFLG-1:0]         flg_clr,
  output logic [CW-1:0]           cnt,
  output logic [NFLG-1:0]         flags,
  output logic [NCMP-1:0]         wave,
  output logic                    blk
);
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            blk_q, blk_d;
  logic [NFLG-1:0] flg_q, flg_d;
  logic [NCMP-1:0] wave_q, wave_d;
  logic [NCMP-1:0] match;
  logic            adv, ovf_ev;

  assign adv    = tick & ~cnt_wr;
  assign ovf_ev = adv & (cnt_q == {CW{1'b1}});

  for (genvar ch = 0; ch < NCMP; ch++) begin : g_chan
    assign match[ch]  = adv & ~blk_q & (cnt_q == cmp[ch]);
    assign wave_d[ch] = wave_q[ch] ^ match[ch];
  end

  always_comb begin
    cnt_d = cnt_q;
    blk_d = blk_q;
    if (cnt_wr) begin
      cnt_d = wdata;
      blk_d = 1'b1;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
      blk_d = 1'b0;
    end
    flg_d = (flg_q & ~flg_clr) | {match, ovf_ev};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      blk_q  <= 1'b0;
      flg_q  <= '0;
      wave_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      blk_q  <= blk_d;
      flg_q  <= flg_d;
      wave_q <= wave_d;
    end
  end

  assign cnt   = cnt_q;
  assign flags = flg_q;
  assign wave  = wave_q;
  assign blk   = blk_q;
endmodule

// File: rtl/tc8_dualcmp.sv
module tc8_dualcmp
  import tc8_pkg::*;
#(
  parameter int CW     = 8,
  parameter int PSC_W  = 10,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_pin,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rd_data,
  output logic          irq_ovf,
  output logic          irq_cmp_a,
  output logic          irq_cmp_b,
  output logic          wave_a,
  output logic          wave_b
);
  logic [NCMP-1:0][CW-1:0] cmp;
  logic [NFLG-1:0]         mask, flags, flg_clr;
  logic [NCMP-1:0]         wave;
  logic [CW-1:0]           cnt;
  clk_sel_e                sel;
  logic                    tick, cnt_wr, blk;

  assign cnt_wr  = wr_en & (addr == A_CNT);
  assign flg_clr = (wr_en && addr == A_FLAG) ? wdata[NFLG-1:0] : '0;

  tc8_clksel #(.PSC_W(PSC_W), .SYNC_N(SYNC_N)) u_clksel (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ext_pin(ext_pin), .tick(tick)
  );

  tc8_cfg #(.CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cmp(cmp), .mask(mask), .sel(sel)
  );

  tc8_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .wdata(wdata),
    .cmp(cmp), .flg_clr(flg_clr), .cnt(cnt), .flags(flags), .wave(wave),
    .blk(blk)
  );

  always_comb begin
    case (addr)
      A_CNT:   rd_data = cnt;
      A_CMPA:  rd_data = cmp[0];
      A_CMPB:  rd_data = cmp[1];
      A_MASK:  rd_data = CW'(mask);
      A_FLAG:  rd_data = CW'(flags);
      A_CTRL:  rd_data = CW'(sel);
      default: rd_data = '0;
    endcase
  end

  assign irq_ovf   = flags[F_OVF] & mask[F_OVF];
  assign irq_cmp_a = flags[F_CA] & mask[F_CA];
  assign irq_cmp_b = flags[F_CB] & mask[F_CB];
  assign wave_a    = wave[0];
  assign wave_b    = wave[1];
endmodule

// File: rtl/tc8_dualcmp_chk.sv
module tc8_dualcmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cnt_wr,
  input logic       blk,
  input logic [7:0] cnt,
  input logic [7:0] wdata,
  input logic [2:0] flags,
  input logic [2:0] sel,
  input logic [2:0] addr,
  input logic [7:0] rd_data,
  input logic       wave_a,
  input logic       wave_b,
  input logic       irq_ovf,
  input logic       irq_cmp_a,
  input logic       irq_cmp_b
);
  assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && !cnt_wr) |=> $stable(cnt));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata)));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt == 8'hFF) |=> (cnt == 8'h00 && flags[0]));

  assert_idle_wave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(wave_a) && $stable(wave_b)));

  assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && tick && !cnt_wr) |=> ($stable(wave_a) && $stable(wave_b)));

  assert_irq_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> flags[0]);
  assert_irq_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp_a |-> flags[1]);
  assert_irq_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp_b |-> flags[2]);

  assert_rsv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd3 || addr == 3'd4 || addr == 3'd5) |-> (rd_data[7:3] == 5'd0));
endmodule

bind tc8_dualcmp tc8_dualcmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .blk(blk),
  .cnt(cnt), .wdata(wdata), .flags(flags), .sel(sel), .addr(addr),
  .rd_data(rd_data), .wave_a(wave_a), .wave_b(wave_b), .irq_ovf(irq_ovf),
  .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b)
);

// File: tb/tc8_dualcmp_tb.sv
`timescale 1ns/1ps
module tc8_dualcmp_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rd_data;
  logic       irq_ovf, irq_cmp_a, irq_cmp_b, wave_a, wave_b;

  int n_tests = 0;
  int n_fail  = 0;

  // model state, built from the requirements
  logic [9:0] m_psc = '0;
  logic       m_s1 = 0, m_s2 = 0, m_pv = 0;
  logic [7:0] m_cnt = 0, m_ca = 0, m_cb = 0;
  logic [2:0] m_msk = 0, m_flg = 0, m_cs = 0;
  logic       m_blk = 0, m_wa = 0, m_wb = 0;

  always #2.5 clk = ~clk;

  tc8_dualcmp u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .irq_ovf(irq_ovf), .irq_cmp_a(irq_cmp_a),
    .irq_cmp_b(irq_cmp_b), .wave_a(wave_a), .wave_b(wave_b)
  );

  function automatic logic model_tick();
    case (m_cs)
      3'd1: return 1'b1;
      3'd2: return m_psc[2:0] == 3'h7;
      3'd3: return m_psc[5:0] == 6'h3F;
      3'd4: return m_psc[7:0] == 8'hFF;
      3'd5: return m_psc == 10'h3FF;
      3'd6: return !m_s2 && m_pv;
      3'd7: return m_s2 && !m_pv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_ca;
      3'd2: return m_cb;
      3'd3: return {5'd0, m_msk};
      3'd4: return {5'd0, m_flg};
      3'd5: return {5'd0, m_cs};
      default: return 8'd0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R4";
      3'd1, 3'd2: return "R6";
      3'd3: return "R10";
      3'd4: return "R8";
      3'd5: return "R2";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      logic tk, cw, et, ma, mb, ov;
      logic [2:0] clr;
      tk  = model_tick();
      cw  = wr_en && addr == 3'd0;
      et  = tk && !cw;
      ma  = et && !m_blk && m_cnt == m_ca;
      mb  = et && !m_blk && m_cnt == m_cb;
      ov  = et && m_cnt == 8'hFF;
      clr = (wr_en && addr == 3'd4) ? wdata[2:0] : 3'd0;
      m_flg = (m_flg & ~clr) | {mb, ma, ov};
      m_wa  = m_wa ^ ma;
      m_wb  = m_wb ^ mb;
      if (cw) begin m_cnt = wdata; m_blk = 1'b1; end
      else if (et) begin m_cnt = m_cnt + 8'd1; m_blk = 1'b0; end
      if (wr_en) begin
        case (addr)
          3'd1: m_ca = wdata;
          3'd2: m_cb = wdata;
          3'd3: m_msk = wdata[2:0];
          3'd5: m_cs = wdata[2:0];
          default: ;
        endcase
      end
      m_pv  = m_s2;
      m_s2  = m_s1;
      m_s1  = ext_pin;
      m_psc = m_psc + 10'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one cycle: at the falling edge compare outputs with the model, then drive
  task automatic cycle(input logic w, input logic [2:0] a, input logic [7:0] d, input logic p);
    @(negedge clk);
    chk(addr_tag(addr), rd_data, exp_rd(addr));
    chk("R9", {irq_cmp_b, irq_cmp_a, irq_ovf}, m_flg & m_msk);
    chk("R6", {wave_b, wave_a}, {m_wb, m_wa});
    wr_en = w; addr = a; wdata = d; ext_pin = p;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [7:0] exp, input string req);
    cycle(1'b0, a, 8'd0, ext_pin);
    @(negedge clk);
    chk(req, rd_data, exp);
    chk(addr_tag(a), rd_data, exp_rd(a));
    @(posedge clk);
  endtask

  initial begin
    #750000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state on every address and output
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      addr = 3'(i);
      #1;
      chk("R1", rd_data, 8'd0);
      chk("R1", {irq_ovf, irq_cmp_a, irq_cmp_b, wave_a, wave_b}, 5'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R10: reserved bits of mask and clock select
    cycle(1'b1, 3'd3, 8'hFF, 1'b0);
    rd_expect(3'd3, 8'h07, "R10");
    cycle(1'b1, 3'd6, 8'hAA, 1'b0);
    rd_expect(3'd6, 8'h00, "R4");

    // R7 / R6: blocked match after a counter write, then a real match
    cycle(1'b1, 3'd4, 8'h07, 1'b0);
    cycle(1'b1, 3'd1, 8'h10, 1'b0);
    cycle(1'b1, 3'd2, 8'h80, 1'b0);
    cycle(1'b1, 3'd0, 8'h10, 1'b0);
    cycle(1'b1, 3'd5, 8'h01, 1'b0);
    cycle(1'b1, 3'd5, 8'h00, 1'b0);
    rd_expect(3'd0, 8'h11, "R7");
    rd_expect(3'd4, 8'h00, "R7");
    chk("R7", wave_a, 1'b0);
    cycle(1'b1, 3'd0, 8'h0F, 1'b0);
    cycle(1'b1, 3'd5, 8'h01, 1'b0);
    cycle(1'b1, 3'd5, 8'h01, 1'b0);
    cycle(1'b1, 3'd5, 8'h00, 1'b0);
    rd_expect(3'd4, 8'h02, "R6");
    chk("R6", wave_a, 1'b1);
    chk("R9", irq_cmp_a, 1'b1);

    // R5 / R8: wrap sets overflow, write-one clears only that bit
    cycle(1'b1, 3'd0, 8'hFF, 1'b0);
    cycle(1'b1, 3'd5, 8'h01, 1'b0);
    cycle(1'b1, 3'd5, 8'h00, 1'b0);
    rd_expect(3'd0, 8'h00, "R5");
    rd_expect(3'd4, 8'h03, "R5");
    cycle(1'b1, 3'd4, 8'h01, 1'b0);
    rd_expect(3'd4, 8'h02, "R8");

    // R4: write collides with a count enable, write wins
    cycle(1'b1, 3'd5, 8'h01, 1'b0);
    cycle(1'b1, 3'd0, 8'h40, 1'b0);
    cycle(1'b1, 3'd5, 8'h00, 1'b0);
    rd_expect(3'd0, 8'h41, "R4");

    // R3: rising-edge source, three-edge latency, then falling-edge source
    cycle(1'b1, 3'd0, 8'h00, 1'b0);
    cycle(1'b1, 3'd5, 8'h07, 1'b0);
    cycle(1'b0, 3'd0, 8'h00, 1'b0);
    cycle(1'b0, 3'd0, 8'h00, 1'b0);
    cycle(1'b0, 3'd0, 8'h00, 1'b1);
    cycle(1'b0, 3'd0, 8'h00, 1'b1);
    cycle(1'b0, 3'd0, 8'h00, 1'b1);
    chk("R3", rd_data, 8'h00);
    cycle(1'b0, 3'd0, 8'h00, 1'b1);
    chk("R3", rd_data, 8'h01);
    cycle(1'b0, 3'd0, 8'h00, 1'b0);
    cycle(1'b0, 3'd0, 8'h00, 1'b0);
    cycle(1'b0, 3'd0, 8'h00, 1'b0);
    cycle(1'b0, 3'd0, 8'h00, 1'b0);
    chk("R3", rd_data, 8'h01);
    cycle(1'b1, 3'd5, 8'h06, 1'b0);
    cycle(1'b0, 3'd0, 8'h00, 1'b1);
    for (int i = 0; i < 4; i++) cycle(1'b0, 3'd0, 8'h00, 1'b0);
    chk("R3", rd_data, 8'h02);

    // R2: one enable per 8 clocks
    cycle(1'b1, 3'd0, 8'h00, 1'b0);
    cycle(1'b1, 3'd5, 8'h02, 1'b0);
    for (int i = 0; i < 80; i++) cycle(1'b0, 3'd0, 8'h00, 1'b0);
    chk("R2", rd_data, exp_rd(3'd0));
    chk("R2", (rd_data >= 8'd9 && rd_data <= 8'd11), 1'b1);

    // constrained random traffic against the model
    for (int i = 0; i < 30000; i++) begin
      logic w;
      logic [2:0] a;
      logic [7:0] d;
      logic p;
      int r;
      r = $urandom_range(0, 99);
      w = r < 30;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (w && a == 3'd0 && $urandom_range(0, 1) == 0) d = m_ca;
      if (w && a == 3'd5) begin
        case ($urandom_range(0, 9))
          0: d = 8'd0;
          1: d = 8'd2;
          2: d = 8'd3;
          3: d = 8'd6;
          4: d = 8'd7;
          5: d = 8'd4;
          default: d = 8'd1;
        endcase
      end
      p = ($urandom_range(0, 2) == 0) ? ~ext_pin : ext_pin;
      cycle(w, a, d, p);
    end
    cycle(1'b0, 3'd0, 8'h00, ext_pin);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule